// File: doc/BRIEF.md
# Floating-Point Control and Status Register

This block holds the 32-bit control and status word of a floating-point unit. The word carries the rounding mode, the flush-to-zero control, the compare condition bit, five trap enables, five sticky flags and six per-operation cause bits. Software loads the whole word through a write port and reads it back as one packed word. The execution pipeline reports each operation's outcome through an event port: a start pulse that clears the causes, a mask of the exceptions raised, and an optional compare result.

For each reported exception the block sets the cause bit. If that exception's enable is set, it requests a trap. If not, it sets the sticky flag instead. An unimplemented-operation event always traps. A software write that leaves a cause set together with its enable, or that leaves the unimplemented cause set, also requests a trap. The trap request is a registered one-cycle pulse. The block also evaluates floating-point conditional branches against the compare bit. It reports whether the branch is taken and, for the likely forms, whether the delay slot must be annulled.

Top module: `fpcsr_unit`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge) the word reads 0, and `trap_req`, `br_taken` and `br_annul` are 0.
- R2: An accepted software write loads the word at the next edge. The layout is:
  - rounding mode in [1:0]
  - flags in [6:2]
  - enables in [11:7]
  - causes in [17:12]
  - compare in bit 23
  - flush-to-zero in bit 24

  All other bits read 0.
- R3: In the flags, enables and causes fields the order from the low bit up is inexact, underflow, overflow, divide-by-zero, invalid. On an event (`ev_valid`) each raised bit sets its cause. If its enable is set, `trap_req` is 1 in the next cycle and the flag is unchanged. Otherwise the flag is set and that bit requests no trap.
- R4: `ev_mask[5]` (unimplemented) sets cause bit 17 and always requests a trap, whatever the enables hold.
- R5: `op_start` clears all six cause bits before the events of the same cycle are recorded. Flags, enables, rounding mode and flush-to-zero are left unchanged.
- R6: After an accepted software write, `trap_req` is 1 for one cycle if either of these holds in the written value:
  - a cause bit in [16:12] is set together with the enable five bits below it
  - bit 17 is set
- R7: A software write in a cycle in which `op_start`, `ev_valid` or `cmp_valid` is high is discarded entirely. The hardware update wins.
- R8: Several events raised in the same cycle are all recorded in that cycle. A single `trap_req` pulse results if any of them traps, and `trap_req` falls again if no trap cause follows.
- R9: `cmp_valid` loads `cmp_value` into bit 23.
- R10: A branch request (`br_valid`) is evaluated against the compare bit held before the edge. One cycle later `br_taken` = usable AND (`br_on_true` ? compare : NOT compare), and `br_annul` = usable AND `br_likely` AND NOT taken. Both outputs are 0 when `fpu_usable` is 0 or when no branch was requested.
- R11: `rnd_mode` mirrors bits [1:0] and `ftz` mirrors bit 24. Rounding encodings: 0 is nearest-even, 1 is toward zero, 2 is toward plus infinity and 3 is toward minus infinity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write word |
| rd_data | output | 32 | Packed register word |
| op_start | input | 1 | Start of a floating-point operation; clears causes |
| ev_valid | input | 1 | Exception mask valid |
| ev_mask | input | 6 | Exceptions raised: inexact, underflow, overflow, divide-by-zero, invalid, unimplemented (bit 0 up) |
| cmp_valid | input | 1 | Compare result valid |
| cmp_value | input | 1 | Compare result |
| trap_req | output | 1 | One-cycle trap request |
| br_valid | input | 1 | Branch request |
| br_on_true | input | 1 | 1: branch on true, 0: branch on false |
| br_likely | input | 1 | Likely form of the branch |
| fpu_usable | input | 1 | Coprocessor usable |
| br_taken | output | 1 | Branch taken (registered) |
| br_annul | output | 1 | Delay slot to be annulled (registered) |
| rnd_mode | output | 2 | Current rounding mode |
| ftz | output | 1 | Current flush-to-zero control |

## Verification
The bench targets the following corner cases; the effect of getting each one wrong is noted alongside:

- **Enabled exception.** A design that sets the flag as well as trapping would show a flag bit that the model leaves clear.
- **Unimplemented event with all enables clear.** A design that gates this event by an enable would miss the trap pulse.
- **Start pulse together with new events.** A design that clears causes after recording would lose the new causes; one that keeps old causes would show stale bits.
- **Software write colliding with hardware activity.** A design that lets the write through would load the enables from the write.
- **Writes of all ones and of cause/enable combinations.** These expose reserved bits that read back nonzero or a write-time trap that is missed.

A long stretch of mixed random traffic, including branch requests with the unit unusable, is also compared cycle by cycle against a behavioural model.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
  localparam int WORD_W    = 32;
  localparam int RM_W      = 2;
  localparam int EXC_N     = 5;
  localparam int CAUSE_N   = EXC_N + 1;
  localparam int UNIMP_IDX = EXC_N;
  localparam int RM_LSB    = 0;
  localparam int FLAG_LSB  = RM_LSB + RM_W;
  localparam int EN_LSB    = FLAG_LSB + EXC_N;
  localparam int CAUSE_LSB = EN_LSB + EXC_N;
  localparam int CMP_BIT   = 23;
  localparam int FS_BIT    = 24;

  typedef struct packed {
    logic               fs;
    logic               cmp;
    logic [CAUSE_N-1:0] cause;
    logic [EXC_N-1:0]   en;
    logic [EXC_N-1:0]   flag;
    logic [RM_W-1:0]    rm;
  } csr_t;

  function automatic logic [WORD_W-1:0] csr_pack(input csr_t s);
    logic [WORD_W-1:0] w;
    w = '0;
    w[RM_LSB +: RM_W]        = s.rm;
    w[FLAG_LSB +: EXC_N]     = s.flag;
    w[EN_LSB +: EXC_N]       = s.en;
    w[CAUSE_LSB +: CAUSE_N]  = s.cause;
    w[CMP_BIT]               = s.cmp;
    w[FS_BIT]                = s.fs;
    return w;
  endfunction

  function automatic csr_t csr_unpack(input logic [WORD_W-1:0] w);
    csr_t s;
    s.rm    = w[RM_LSB +: RM_W];
    s.flag  = w[FLAG_LSB +: EXC_N];
    s.en    = w[EN_LSB +: EXC_N];
    s.cause = w[CAUSE_LSB +: CAUSE_N];
    s.cmp   = w[CMP_BIT];
    s.fs    = w[FS_BIT];
    return s;
  endfunction
endpackage

// File: rtl/fpcsr_event.sv
module fpcsr_event
  import fpcsr_pkg::*;
#(
  parameter int N_EXC = EXC_N
) (
  input  logic [N_EXC-1:0] cur_flag,
  input  logic [N_EXC-1:0] cur_en,
  input  logic [N_EXC:0]   cur_cause,
  input  logic             op_start,
  input  logic             ev_valid,
  input  logic [N_EXC:0]   ev_mask,
  output logic [N_EXC-1:0] nxt_flag,
  output logic [N_EXC:0]   nxt_cause,
  output logic             ev_trap
);
  localparam int UI = N_EXC;

  logic [N_EXC:0]   hit;
  logic [N_EXC:0]   base_cause;
  logic [N_EXC-1:0] trap_vec;

  assign hit        = ev_valid ? ev_mask : '0;
  assign base_cause = op_start ? '0 : cur_cause;

  for (genvar i = 0; i < N_EXC; i++) begin : g_exc
    assign trap_vec[i]  = hit[i] & cur_en[i];
    assign nxt_flag[i]  = cur_flag[i] | (hit[i] & ~cur_en[i]);
    assign nxt_cause[i] = base_cause[i] | hit[i];
  end

  assign nxt_cause[UI] = base_cause[UI] | hit[UI];
  assign ev_trap       = (|trap_vec) | hit[UI];
endmodule

// File: rtl/fpcsr_wrtrap.sv
module fpcsr_wrtrap
  import fpcsr_pkg::*;
(
  input  logic [WORD_W-1:0] wdata,
  output logic              wr_trap
);
  csr_t w;
  assign w       = csr_unpack(wdata);
  assign wr_trap = (|(w.cause[EXC_N-1:0] & w.en)) | w.cause[UNIMP_IDX];
endmodule

// File: rtl/fpcsr_branch.sv
module fpcsr_branch (
  input  logic clk,
  input  logic rst,
  input  logic br_valid,
  input  logic br_on_true,
  input  logic br_likely,
  input  logic fpu_usable,
  input  logic cond_bit,
  output logic br_taken,
  output logic br_annul
);
  logic go, take;
  assign go   = br_valid & fpu_usable;
  assign take = br_on_true ? cond_bit : ~cond_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      br_taken <= 1'b0;
      br_annul <= 1'b0;
    end else begin
      br_taken <= go & take;
      br_annul <= go & br_likely & ~take;
    end
  end
endmodule

// File: rtl/fpcsr_unit.sv
module fpcsr_unit
  import fpcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_we,
  input  logic [WORD_W-1:0] sw_wdata,
  output logic [WORD_W-1:0] rd_data,
  input  logic              op_start,
  input  logic              ev_valid,
  input  logic [CAUSE_N-1:0] ev_mask,
  input  logic              cmp_valid,
  input  logic              cmp_value,
  output logic              trap_req,
  input  logic              br_valid,
  input  logic              br_on_true,
  input  logic              br_likely,
  input  logic              fpu_usable,
  output logic              br_taken,
  output logic              br_annul,
  output logic [RM_W-1:0]   rnd_mode,
  output logic              ftz
);
  csr_t               csr_q, csr_d;
  logic               hw_busy, sw_take;
  logic [EXC_N-1:0]   nxt_flag;
  logic [CAUSE_N-1:0] nxt_cause;
  logic               ev_trap, wr_trap;

  assign hw_busy = op_start | ev_valid | cmp_valid;
  assign sw_take = sw_we & ~hw_busy;

  fpcsr_event #(.N_EXC(EXC_N)) u_event (
    .cur_flag (csr_q.flag),
    .cur_en   (csr_q.en),
    .cur_cause(csr_q.cause),
    .op_start (op_start),
    .ev_valid (ev_valid),
    .ev_mask  (ev_mask),
    .nxt_flag (nxt_flag),
    .nxt_cause(nxt_cause),
    .ev_trap  (ev_trap)
  );

  fpcsr_wrtrap u_wrtrap (
    .wdata  (sw_wdata),
    .wr_trap(wr_trap)
  );

  fpcsr_branch u_branch (
    .clk       (clk),
    .rst       (rst),
    .br_valid  (br_valid),
    .br_on_true(br_on_true),
    .br_likely (br_likely),
    .fpu_usable(fpu_usable),
    .cond_bit  (csr_q.cmp),
    .br_taken  (br_taken),
    .br_annul  (br_annul)
  );

  always_comb begin
    if (sw_take) begin
      csr_d = csr_unpack(sw_wdata);
    end else begin
      csr_d       = csr_q;
      csr_d.flag  = nxt_flag;
      csr_d.cause = nxt_cause;
      if (cmp_valid) csr_d.cmp = cmp_value;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_q    <= '0;
      trap_req <= 1'b0;
    end else begin
      csr_q    <= csr_d;
      trap_req <= ev_trap | (sw_take & wr_trap);
    end
  end

  assign rd_data  = csr_pack(csr_q);
  assign rnd_mode = csr_q.rm;
  assign ftz      = csr_q.fs;
endmodule

// File: rtl/fpcsr_chk.sv
module fpcsr_chk
  import fpcsr_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               sw_we,
  input logic               op_start,
  input logic               ev_valid,
  input logic [CAUSE_N-1:0] ev_mask,
  input logic               cmp_valid,
  input logic               fpu_usable,
  input logic [WORD_W-1:0]  rd_data,
  input logic               trap_req,
  input logic               br_taken
);
  localparam logic [WORD_W-1:0] LIVE_MASK = 32'h0183_FFFF;

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~LIVE_MASK) == '0);

  // R4
  unimp_trap_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_mask[UNIMP_IDX]) |=> trap_req);

  // R3
  cause_set_chk: assert property (@(posedge clk) disable iff (rst)
    ev_valid |=> ((rd_data[CAUSE_LSB +: CAUSE_N] & $past(ev_mask)) == $past(ev_mask)));

  // R3
  enabled_flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ev_valid |=> ((rd_data[FLAG_LSB +: EXC_N] & $past(rd_data[EN_LSB +: EXC_N]))
                  == ($past(rd_data[FLAG_LSB +: EXC_N]) & $past(rd_data[EN_LSB +: EXC_N]))));

  // R7
  hw_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_we && (op_start || ev_valid || cmp_valid)) |=> $stable(rd_data[EN_LSB +: EXC_N]));

  // R10
  unusable_no_branch_chk: assert property (@(posedge clk) disable iff (rst)
    !fpu_usable |=> !br_taken);
endmodule

bind fpcsr_unit fpcsr_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .sw_we     (sw_we),
  .op_start  (op_start),
  .ev_valid  (ev_valid),
  .ev_mask   (ev_mask),
  .cmp_valid (cmp_valid),
  .fpu_usable(fpu_usable),
  .rd_data   (rd_data),
  .trap_req  (trap_req),
  .br_taken  (br_taken)
);

// File: tb/sim_fpcsr_unit.sv
module sim_fpcsr_unit;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst, sw_we, op_start, ev_valid, cmp_valid, cmp_value;
  logic        br_valid, br_on_true, br_likely, fpu_usable;
  logic [31:0] sw_wdata;
  logic [5:0]  ev_mask;
  logic [31:0] rd_data;
  logic        trap_req, br_taken, br_annul, ftz;
  logic [1:0]  rnd_mode;

  fpcsr_unit u0 (
    .clk(clk), .rst(rst), .sw_we(sw_we), .sw_wdata(sw_wdata), .rd_data(rd_data),
    .op_start(op_start), .ev_valid(ev_valid), .ev_mask(ev_mask),
    .cmp_valid(cmp_valid), .cmp_value(cmp_value), .trap_req(trap_req),
    .br_valid(br_valid), .br_on_true(br_on_true), .br_likely(br_likely),
    .fpu_usable(fpu_usable), .br_taken(br_taken), .br_annul(br_annul),
    .rnd_mode(rnd_mode), .ftz(ftz)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // behavioural model state
  logic [1:0] m_rm;
  logic [4:0] m_flag, m_en;
  logic [5:0] m_cause;
  logic       m_cmp, m_fs, m_trap, m_bt, m_ba;

  function automatic logic [31:0] m_word();
    return {7'd0, m_fs, m_cmp, 5'd0, m_cause, m_en, m_flag, m_rm};
  endfunction

  task automatic model_edge();
    logic [4:0] wf, we;
    logic [5:0] wc;
    logic t, hit, cond;
    if (rst) begin
      m_rm = 0; m_flag = 0; m_en = 0; m_cause = 0; m_cmp = 0; m_fs = 0;
      m_trap = 0; m_bt = 0; m_ba = 0;
      return;
    end
    cond = br_on_true ? m_cmp : !m_cmp;
    m_bt = br_valid && fpu_usable && cond;
    m_ba = br_valid && fpu_usable && br_likely && !cond;
    t = 0;
    if (sw_we && !(op_start || ev_valid || cmp_valid)) begin
      m_rm = sw_wdata[1:0];
      wf = sw_wdata[6:2]; we = sw_wdata[11:7]; wc = sw_wdata[17:12];
      m_flag = wf; m_en = we; m_cause = wc;
      m_cmp = sw_wdata[23]; m_fs = sw_wdata[24];
      for (int i = 0; i < 5; i++) if (wc[i] && we[i]) t = 1;
      if (wc[5]) t = 1;
    end else begin
      if (op_start) m_cause = 0;
      if (ev_valid) begin
        for (int i = 0; i < 6; i++) begin
          hit = ev_mask[i];
          if (hit) begin
            m_cause[i] = 1;
            if (i == 5) t = 1;
            else if (m_en[i]) t = 1;
            else m_flag[i] = 1;
          end
        end
      end
      if (cmp_valid) m_cmp = cmp_value;
    end
    m_trap = t;
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(string req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(req, "rd_data", rd_data, m_word());
    chk(req, "trap_req", {31'd0, trap_req}, {31'd0, m_trap});
    chk(req, "br_taken", {31'd0, br_taken}, {31'd0, m_bt});
    chk(req, "br_annul", {31'd0, br_annul}, {31'd0, m_ba});
    chk("R11", "rnd_mode", {30'd0, rnd_mode}, {30'd0, m_rm});
    chk("R11", "ftz", {31'd0, ftz}, {31'd0, m_fs});
  endtask

  task automatic idle();
    sw_we = 0; sw_wdata = 0; op_start = 0; ev_valid = 0; ev_mask = 0;
    cmp_valid = 0; cmp_value = 0; br_valid = 0; br_on_true = 0; br_likely = 0;
    fpu_usable = 1;
  endtask

  task automatic wr(logic [31:0] v, string req);
    idle(); sw_we = 1; sw_wdata = v; step(req); idle();
  endtask

  task automatic ev(logic st, logic [5:0] m, string req);
    idle(); op_start = st; ev_valid = 1; ev_mask = m; step(req); idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle(); rst = 1;
    step("R1"); step("R1");
    rst = 0;
    step("R1");
    // R2: all ones, reserved bits read zero, write-time trap
    wr(32'hFFFF_FFFF, "R2"); step("R6");
    wr(32'h0000_0003, "R2"); step("R11");
    wr(32'h0180_0002, "R11"); step("R9");
    // R6: cause with matching enable
    wr(32'h0000_4200, "R6"); step("R6");
    // R6: cause without enable, no trap
    wr(32'h0000_4100, "R6"); step("R6");
    // R6: unimplemented cause alone
    wr(32'h0002_0000, "R6"); step("R6");
    // R3: enables off, flags set, no trap
    wr(32'h0, "R3");
    ev(1, 6'b000001, "R3"); step("R3");
    ev(1, 6'b010000, "R3");
    // R4: unimplemented with no enables
    ev(1, 6'b100000, "R4"); step("R4");
    // R3: enabled overflow traps, flag untouched
    wr(32'h0000_0200, "R3");
    ev(1, 6'b000100, "R3"); step("R3");
    // R5: start clears causes, new event recorded same cycle
    ev(0, 6'b000010, "R5");
    ev(1, 6'b001000, "R5");
    idle(); op_start = 1; step("R5"); idle();
    // R8: several events in one cycle, single pulse
    wr(32'h0000_0F80, "R8");
    ev(1, 6'b111111, "R8"); step("R8"); step("R8");
    // R7: write colliding with hardware activity dropped
    idle(); sw_we = 1; sw_wdata = 32'h0000_0000; ev_valid = 1; ev_mask = 6'b000001; step("R7");
    idle(); sw_we = 1; sw_wdata = 32'hFFFF_FFFF; cmp_valid = 1; cmp_value = 1; step("R7");
    idle(); sw_we = 1; sw_wdata = 32'h0002_0000; op_start = 1; step("R7");
    // R9/R10: compare then branches in all forms
    for (int c = 0; c < 2; c++) begin
      idle(); cmp_valid = 1; cmp_value = c[0]; step("R9");
      for (int k = 0; k < 8; k++) begin
        idle(); br_valid = 1; br_on_true = k[0]; br_likely = k[1]; fpu_usable = k[2];
        step("R10");
      end
      idle(); step("R10");
    end
    // mixed traffic
    for (int n = 0; n < 2000; n++) begin
      idle();
      sw_we = ($urandom % 4) == 0; sw_wdata = $urandom;
      if (($urandom % 8) == 0) sw_wdata[17] = 1'b0;
      op_start = ($urandom % 3) == 0;
      ev_valid = ($urandom % 3) == 0; ev_mask = $urandom;
      if (($urandom % 2) == 0) ev_mask[5] = 1'b0;
      cmp_valid = ($urandom % 4) == 0; cmp_value = $urandom;
      br_valid = $urandom; br_on_true = $urandom; br_likely = $urandom;
      fpu_usable = ($urandom % 4) != 0;
      step("R8");
    end
    idle(); rst = 1; step("R1"); rst = 0; step("R1");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule